// File: doc/BRIEF.md
# Write-Through Data Cache with Store Queue

This block is a direct-mapped data cache that sits between a processor load/store port and a slower backing memory. Reads that hit return a word one cycle after acceptance. Reads that miss fetch a whole line from memory through a line-fill port, store it, and return the requested word. Stores use a write-through, no-write-allocate policy. A store updates the cached word only when the line is present. Every store is placed in a small first-in first-out store queue, and the cache never fetches a line because of a store.

A separate drain engine empties the store queue toward memory, one word write at a time. It waits for the memory's acknowledge before presenting the next entry. The processor stalls in only two cases: a store arrives while the queue is full, or a read misses. A read miss first checks the queue for a pending store to the same line. While such a store remains unacknowledged, the fill request is held back, so the returned line always includes every earlier store.

Processor requests use valid/ready. A request must stay stable while `cpu_req_valid` is high and `cpu_req_ready` is low, and it is taken on the edge where both are high. The memory-side fill request also uses valid/ready and holds its address until accepted. A queued write is offered on `mem_wr_valid` with its address and data, and stays stable until the edge where `mem_wr_ack` is high. Read responses and fill responses are single-cycle pulses and cannot be back-pressured.

Top module: `wtc_cache`

## Requirements
- R1: With default parameters, byte address bits [4:0] select the byte within a 32-byte line, bits [4:2] select the 32-bit word, bits [9:5] select one of 32 lines, and bits [31:10] form the tag. A read hits only if the line's valid bit is set and its stored tag equals the address tag. Two addresses that share an index but differ in tag evict each other.
- R2: After reset every line is invalid, so the first read of any address misses. Out of reset, `cpu_req_ready` is high and `cpu_rsp_valid`, `mem_wr_valid` and `mem_rd_req_valid` are low.
- R3: A read miss issues exactly one fill request. The request address is the line address with its low 5 bits zero, and it is held stable until accepted. On the fill response the line is stored and the requested word is returned. Later reads to that line cause no memory traffic.
- R4: A read hit raises `cpu_rsp_valid` with the cached word in the cycle after the acceptance edge.
- R5: A store that hits replaces the cached word. A later read of that word hits and returns the stored value.
- R6: A store that misses does not fetch the line. A later read of that line still misses.
- R7: Every accepted store appears exactly once on the memory write port, with its own address and data, in acceptance order.
- R8: The store queue holds 4 entries. With no acknowledges, 4 stores are accepted without a stall. A fifth store sees `cpu_req_ready` low until an entry drains.
- R9: Only one memory write is outstanding at a time. Its address and data stay stable until the acknowledge edge.
- R10: If a read miss finds an unacknowledged queued store to the same line, no fill request is issued until that store is acknowledged. The data returned then includes the store.
- R11: A read miss whose line has no queued store issues its fill without waiting for other queued stores to drain.
- R12: While a read miss is being served, `cpu_req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Request taken on this edge if valid |
| cpu_req_we | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Word-aligned byte address |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_rsp_valid | output | 1 | Load data pulse |
| cpu_rsp_rdata | output | DATA_W | Load data |
| mem_rd_req_valid | output | 1 | Line fill request |
| mem_rd_req_ready | input | 1 | Memory takes the fill request |
| mem_rd_req_addr | output | ADDR_W | Line-aligned fill address |
| mem_rd_rsp_valid | input | 1 | Fill data pulse |
| mem_rd_rsp_line | input | LINE_BYTES*8 | Fill line, word 0 in the low bits |
| mem_wr_valid | output | 1 | Queued store offered to memory |
| mem_wr_addr | output | ADDR_W | Store address |
| mem_wr_data | output | DATA_W | Store data |
| mem_wr_ack | input | 1 | Memory accepts the offered store |

## Verification
A wrong valid bit or tag shows up at once on the memory ports. Either a fill request appears for a read that should hit, or a read that should miss returns an answer in one cycle. A wrong cached word appears as a bad read value on the next access to that word. A store queue that loses, duplicates or reorders an entry is visible only as the queue drains: the write stream no longer matches the bench's list of accepted stores. A missing same-line check shows up later as a stale read, returned right after a fill that was issued too early. The bench keeps an arithmetic model of memory contents and of the store stream, so each of these faults is caught at the first port event it corrupts.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MISS = 2'd1,
    ST_FILL = 2'd2
  } wtc_state_e;
endpackage

// File: rtl/wtc_store_fifo.sv
module wtc_store_fifo #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int DEPTH      = 4,
  parameter int LINE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  output logic              full,
  output logic [$clog2(DEPTH+1)-1:0] count,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              probe_hit,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ack
);
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W  = $clog2(DEPTH+1);
  localparam int BSEL_W = $clog2(LINE_BYTES);

  logic [ADDR_W-1:0] ent_addr [DEPTH];
  logic [DATA_W-1:0] ent_data [DEPTH];
  logic [DEPTH-1:0]  occ_q;
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DEPTH-1:0]  line_match;
  logic              pop;

  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign count     = cnt_q;
  assign out_valid = (cnt_q != '0);
  assign out_addr  = ent_addr[rd_ptr_q];
  assign out_data  = ent_data[rd_ptr_q];
  assign pop       = out_valid && out_ack;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      occ_q    <= '0;
    end else begin
      if (push) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      for (int i = 0; i < DEPTH; i++) begin
        if (push && wr_ptr_q == PTR_W'(i))     occ_q[i] <= 1'b1;
        else if (pop && rd_ptr_q == PTR_W'(i)) occ_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      ent_addr[wr_ptr_q] <= push_addr;
      ent_data[wr_ptr_q] <= push_data;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_probe
    assign line_match[g] = occ_q[g] &&
      (ent_addr[g][ADDR_W-1:BSEL_W] == probe_addr[ADDR_W-1:BSEL_W]);
  end

  assign probe_hit = |line_match;
endmodule

// File: rtl/wtc_line_store.sv
module wtc_line_store #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int LINES      = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       lk_addr,
  output logic                    lk_hit,
  output logic [DATA_W-1:0]       lk_word,
  input  logic                    word_we,
  input  logic [DATA_W-1:0]       word_data,
  input  logic                    fill_en,
  input  logic [ADDR_W-1:0]       fill_addr,
  input  logic [LINE_BYTES*8-1:0] fill_line
);
  localparam int LINE_W  = LINE_BYTES * 8;
  localparam int BSEL_W  = $clog2(LINE_BYTES);
  localparam int WBYTE_W = $clog2(DATA_W / 8);
  localparam int WOFF_W  = BSEL_W - WBYTE_W;
  localparam int IDX_W   = $clog2(LINES);
  localparam int TAG_W   = ADDR_W - IDX_W - BSEL_W;

  logic [LINE_W-1:0] data_q [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINES-1:0]  valid_q;

  logic [IDX_W-1:0]  lk_idx, fill_idx;
  logic [TAG_W-1:0]  lk_tag, fill_tag;
  logic [WOFF_W-1:0] lk_woff;

  assign lk_idx   = lk_addr[BSEL_W +: IDX_W];
  assign lk_tag   = lk_addr[ADDR_W-1 -: TAG_W];
  assign lk_woff  = lk_addr[WBYTE_W +: WOFF_W];
  assign fill_idx = fill_addr[BSEL_W +: IDX_W];
  assign fill_tag = fill_addr[ADDR_W-1 -: TAG_W];

  assign lk_hit  = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_word = data_q[lk_idx][lk_woff*DATA_W +: DATA_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       valid_q <= '0;
    else if (fill_en) valid_q[fill_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      data_q[fill_idx] <= fill_line;
      tag_q[fill_idx]  <= fill_tag;
    end else if (word_we) begin
      data_q[lk_idx][lk_woff*DATA_W +: DATA_W] <= word_data;
    end
  end
endmodule

// File: rtl/wtc_cache.sv
module wtc_cache
  import wtc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int LINES      = 32,
  parameter int WB_DEPTH   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_req_valid,
  output logic                    cpu_req_ready,
  input  logic                    cpu_req_we,
  input  logic [ADDR_W-1:0]       cpu_req_addr,
  input  logic [DATA_W-1:0]       cpu_req_wdata,
  output logic                    cpu_rsp_valid,
  output logic [DATA_W-1:0]       cpu_rsp_rdata,
  output logic                    mem_rd_req_valid,
  input  logic                    mem_rd_req_ready,
  output logic [ADDR_W-1:0]       mem_rd_req_addr,
  input  logic                    mem_rd_rsp_valid,
  input  logic [LINE_BYTES*8-1:0] mem_rd_rsp_line,
  output logic                    mem_wr_valid,
  output logic [ADDR_W-1:0]       mem_wr_addr,
  output logic [DATA_W-1:0]       mem_wr_data,
  input  logic                    mem_wr_ack
);
  localparam int BSEL_W  = $clog2(LINE_BYTES);
  localparam int WBYTE_W = $clog2(DATA_W / 8);
  localparam int WOFF_W  = BSEL_W - WBYTE_W;
  localparam int CNT_W   = $clog2(WB_DEPTH + 1);

  wtc_state_e        state_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [ADDR_W-1:0] lk_addr;
  logic              lk_hit;
  logic [DATA_W-1:0] lk_word;
  logic              fifo_full;
  logic [CNT_W-1:0]  fifo_count;
  logic              line_pending;
  logic              accept, push, word_we, rd_hit_acc, rd_miss_acc, fill_en;
  logic [DATA_W-1:0] fill_word;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic [WOFF_W-1:0] req_woff;

  assign lk_addr       = (state_q == ST_IDLE) ? cpu_req_addr : req_addr_q;
  assign cpu_req_ready = (state_q == ST_IDLE) && (!cpu_req_we || !fifo_full);
  assign accept        = cpu_req_valid && cpu_req_ready;
  assign push          = accept && cpu_req_we;
  assign word_we       = push && lk_hit;
  assign rd_hit_acc    = accept && !cpu_req_we && lk_hit;
  assign rd_miss_acc   = accept && !cpu_req_we && !lk_hit;
  assign fill_en       = (state_q == ST_FILL) && mem_rd_rsp_valid;

  assign mem_rd_req_valid = (state_q == ST_MISS) && !line_pending;
  assign mem_rd_req_addr  = {req_addr_q[ADDR_W-1:BSEL_W], {BSEL_W{1'b0}}};

  assign req_woff  = req_addr_q[WBYTE_W +: WOFF_W];
  assign fill_word = mem_rd_rsp_line[req_woff*DATA_W +: DATA_W];

  assign cpu_rsp_valid = rsp_valid_q;
  assign cpu_rsp_rdata = rsp_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      req_addr_q  <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= rd_hit_acc || fill_en;
      if (rd_hit_acc)   rsp_data_q <= lk_word;
      else if (fill_en) rsp_data_q <= fill_word;
      unique case (state_q)
        ST_IDLE: if (rd_miss_acc) begin
          state_q    <= ST_MISS;
          req_addr_q <= cpu_req_addr;
        end
        ST_MISS: if (mem_rd_req_valid && mem_rd_req_ready) state_q <= ST_FILL;
        ST_FILL: if (mem_rd_rsp_valid) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  wtc_line_store #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES), .LINES(LINES)
  ) u_lines (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_addr   (lk_addr),
    .lk_hit    (lk_hit),
    .lk_word   (lk_word),
    .word_we   (word_we),
    .word_data (cpu_req_wdata),
    .fill_en   (fill_en),
    .fill_addr (req_addr_q),
    .fill_line (mem_rd_rsp_line)
  );

  wtc_store_fifo #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(WB_DEPTH), .LINE_BYTES(LINE_BYTES)
  ) u_queue (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (push),
    .push_addr  (cpu_req_addr),
    .push_data  (cpu_req_wdata),
    .full       (fifo_full),
    .count      (fifo_count),
    .probe_addr (req_addr_q),
    .probe_hit  (line_pending),
    .out_valid  (mem_wr_valid),
    .out_addr   (mem_wr_addr),
    .out_data   (mem_wr_data),
    .out_ack    (mem_wr_ack)
  );
endmodule

// File: rtl/wtc_cache_chk.sv
module wtc_cache_chk #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int WB_DEPTH   = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cpu_req_valid,
  input logic                          cpu_req_ready,
  input logic                          cpu_req_we,
  input logic                          mem_rd_req_valid,
  input logic                          mem_rd_req_ready,
  input logic [ADDR_W-1:0]             mem_rd_req_addr,
  input logic                          mem_wr_valid,
  input logic                          mem_wr_ack,
  input logic [ADDR_W-1:0]             mem_wr_addr,
  input logic [DATA_W-1:0]             mem_wr_data,
  input logic                          fifo_full,
  input logic [$clog2(WB_DEPTH+1)-1:0] fifo_count,
  input logic                          line_pending
);
  localparam int BSEL_W = $clog2(LINE_BYTES);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= ($clog2(WB_DEPTH+1))'(WB_DEPTH)); // R8
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_valid && cpu_req_we && fifo_full |-> !cpu_req_ready); // R8
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && !mem_wr_ack |=> mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)); // R9
  AST_FILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req_valid && !mem_rd_req_ready |=> mem_rd_req_valid && $stable(mem_rd_req_addr)); // R3
  AST_FILL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req_valid |-> mem_rd_req_addr[BSEL_W-1:0] == '0); // R3
  AST_NO_STALE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req_valid |-> !line_pending); // R10
  AST_MISS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req_valid |-> !cpu_req_ready); // R12
endmodule

bind wtc_cache wtc_cache_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES), .WB_DEPTH(WB_DEPTH)
) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .cpu_req_valid    (cpu_req_valid),
  .cpu_req_ready    (cpu_req_ready),
  .cpu_req_we       (cpu_req_we),
  .mem_rd_req_valid (mem_rd_req_valid),
  .mem_rd_req_ready (mem_rd_req_ready),
  .mem_rd_req_addr  (mem_rd_req_addr),
  .mem_wr_valid     (mem_wr_valid),
  .mem_wr_ack       (mem_wr_ack),
  .mem_wr_addr      (mem_wr_addr),
  .mem_wr_data      (mem_wr_data),
  .fifo_full        (fifo_full),
  .fifo_count       (fifo_count),
  .line_pending     (line_pending)
);

// File: tb/test_wtc_cache.sv
module test_wtc_cache;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cpu_req_valid = 1'b0;
  logic         cpu_req_ready;
  logic         cpu_req_we = 1'b0;
  logic [31:0]  cpu_req_addr = '0;
  logic [31:0]  cpu_req_wdata = '0;
  logic         cpu_rsp_valid;
  logic [31:0]  cpu_rsp_rdata;
  logic         mem_rd_req_valid;
  logic         mem_rd_req_ready = 1'b1;
  logic [31:0]  mem_rd_req_addr;
  logic         mem_rd_rsp_valid = 1'b0;
  logic [255:0] mem_rd_rsp_line = '0;
  logic         mem_wr_valid;
  logic [31:0]  mem_wr_addr;
  logic [31:0]  mem_wr_data;
  logic         mem_wr_ack = 1'b0;

  always #4 clk = ~clk;

  wtc_cache i_wtc_cache (.*);

  logic [31:0] bmem [1024];
  logic [31:0] gold [1024];
  logic [31:0] exp_a [512];
  logic [31:0] exp_d [512];
  int exp_wr = 0, exp_rd = 0;
  int checks = 0, fails = 0, fills = 0;
  bit ack_en = 1'b1;
  bit rd_pend = 1'b0;
  int rd_cnt = 0;
  logic [31:0] fill_a = '0;
  logic [31:0] last_fill_a = '0;

  function automatic logic [31:0] init_word(input int w);
    return 32'hC0DE0000 ^ (w * 32'h0001_0003);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // write-port responder and order monitor (R7, R9)
  always @(negedge clk) mem_wr_ack <= mem_wr_valid && ack_en && !mem_wr_ack;

  logic        prev_hold = 1'b0;
  logic [31:0] prev_a = '0, prev_d = '0;
  always @(posedge clk) begin
    if (rst_n) begin
      if (prev_hold) chk(mem_wr_valid && mem_wr_addr == prev_a && mem_wr_data == prev_d,
                         "R9 write held until ack", mem_wr_addr, prev_a);
      prev_hold <= mem_wr_valid && !mem_wr_ack;
      prev_a    <= mem_wr_addr;
      prev_d    <= mem_wr_data;
      if (mem_wr_valid && mem_wr_ack) begin
        if (exp_rd >= exp_wr) chk(1'b0, "R7 unexpected write", mem_wr_addr, 32'hFFFFFFFF);
        else begin
          chk(mem_wr_addr == exp_a[exp_rd] && mem_wr_data == exp_d[exp_rd],
              "R7 write order", mem_wr_data, exp_d[exp_rd]);
          exp_rd++;
        end
        bmem[mem_wr_addr[11:2]] <= mem_wr_data;
      end
    end
  end

  // fill responder
  always @(negedge clk) begin
    mem_rd_rsp_valid <= 1'b0;
    if (rd_pend) begin
      if (rd_cnt == 0) begin
        mem_rd_rsp_valid <= 1'b1;
        for (int w = 0; w < 8; w++)
          mem_rd_rsp_line[w*32 +: 32] <= bmem[{fill_a[11:5], 3'(w)}];
        rd_pend <= 1'b0;
      end else rd_cnt <= rd_cnt - 1;
    end else if (mem_rd_req_valid) begin
      rd_pend     <= 1'b1;
      rd_cnt      <= 2;
      fill_a      <= mem_rd_req_addr;
      last_fill_a <= mem_rd_req_addr;
      fills++;
    end
  end

  task automatic wait_accept(output int waits);
    bit r;
    waits = 0;
    while (1) begin
      #1 r = cpu_req_ready;
      @(posedge clk);
      if (r) break;
      waits++;
      @(negedge clk);
    end
  endtask

  task automatic cpu_read(input logic [31:0] a, output logic [31:0] d, output int lat);
    int w;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_we = 1'b0; cpu_req_addr = a;
    wait_accept(w);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    lat = 1;
    while (!cpu_rsp_valid) begin @(negedge clk); lat++; end
    d = cpu_rsp_rdata;
  endtask

  task automatic cpu_write(input logic [31:0] a, input logic [31:0] d, output int waits);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_we = 1'b1; cpu_req_addr = a; cpu_req_wdata = d;
    wait_accept(waits);
    gold[a[11:2]] = d;
    exp_a[exp_wr] = a; exp_d[exp_wr] = d; exp_wr++;
    @(negedge clk);
    cpu_req_valid = 1'b0; cpu_req_we = 1'b0;
  endtask

  task automatic drain();
    ack_en = 1'b1;
    while (exp_rd != exp_wr) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    logic [31:0] d, a;
    int lat, f0, w;
    for (int i = 0; i < 1024; i++) begin bmem[i] = init_word(i); gold[i] = init_word(i); end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    chk(cpu_req_ready && !cpu_rsp_valid && !mem_wr_valid && !mem_rd_req_valid,
        "R2 reset outputs", {28'd0, cpu_req_ready, cpu_rsp_valid, mem_wr_valid, mem_rd_req_valid}, 32'h8);

    // R2/R3 cold misses on every index, tag 0
    for (int i = 0; i < 32; i++) begin
      a = (i << 5) | ((i % 8) << 2);
      f0 = fills;
      cpu_read(a, d, lat);
      chk(fills == f0 + 1, "R2 first read misses", fills, f0 + 1);
      chk(last_fill_a == (a & 32'hFFFF_FFE0), "R3 fill line address", last_fill_a, a & 32'hFFFF_FFE0);
      chk(d == gold[a[11:2]], "R3 miss data", d, gold[a[11:2]]);
    end

    // R4/R1 every word of every line now hits in one cycle
    f0 = fills;
    for (int i = 0; i < 256; i++) begin
      a = i << 2;
      cpu_read(a, d, lat);
      chk(d == gold[i], "R1 hit data by word select", d, gold[i]);
      chk(lat == 1, "R4 hit latency", lat, 1);
    end
    chk(fills == f0, "R3 no traffic on hits", fills, f0);

    // R1 aliasing: same index, different tag evicts
    for (int i = 0; i < 32; i += 5) begin
      f0 = fills;
      a = (1 << 10) | (i << 5) | 4;
      cpu_read(a, d, lat);
      chk(fills == f0 + 1 && d == gold[a[11:2]], "R1 other tag misses", d, gold[a[11:2]]);
      cpu_read(i << 5, d, lat);
      chk(fills == f0 + 2 && d == gold[i * 8], "R1 evicted tag misses", fills, f0 + 2);
    end

    // R5 store hits update cache
    for (int i = 1; i < 32; i += 3) begin
      a = (i << 5) | ((7 - i % 8) << 2);
      cpu_write(a, 32'h5100_0000 + i, w);
      f0 = fills;
      cpu_read(a, d, lat);
      chk(d == 32'h5100_0000 + i && fills == f0 && lat == 1, "R5 store hit readback", d, 32'h5100_0000 + i);
    end
    drain();

    // R6 store miss: no allocation
    f0 = fills;
    a = (2 << 10) | (3 << 5) | 8;
    cpu_write(a, 32'h6600_0003, w);
    drain();
    chk(fills == f0, "R6 no fill on store miss", fills, f0);
    cpu_read(a, d, lat);
    chk(fills == f0 + 1, "R6 line still absent", fills, f0 + 1);
    chk(d == 32'h6600_0003, "R6 store reached memory", d, 32'h6600_0003);

    // R8 queue depth
    ack_en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      cpu_write((3 << 10) | (i << 5), 32'h8800_0000 + i, w);
      chk(w == 0, "R8 four stores without stall", w, 0);
    end
    fork
      cpu_write((3 << 10) | (4 << 5), 32'h8800_0004, w);
      begin
        repeat (8) @(negedge clk);
        chk(cpu_req_ready == 1'b0, "R8 fifth store stalls", cpu_req_ready, 0);
        ack_en = 1'b1;
      end
    join
    chk(w >= 8, "R8 stall length", w, 8);
    drain();

    // R10 pending same-line store holds the fill, R12 stall during miss
    ack_en = 1'b0;
    a = (3 << 10) | (20 << 5) | 12;
    cpu_write(a, 32'hA10A_0020, w);
    f0 = fills;
    fork
      cpu_read(a, d, lat);
      begin
        repeat (12) @(negedge clk);
        chk(fills == f0, "R10 fill held while store pending", fills, f0);
        chk(cpu_req_ready == 1'b0, "R12 ready low during miss", cpu_req_ready, 0);
        ack_en = 1'b1;
      end
    join
    chk(d == 32'hA10A_0020 && fills == f0 + 1, "R10 data includes store", d, 32'hA10A_0020);
    drain();

    // R11 unrelated pending store does not block the fill
    ack_en = 1'b0;
    cpu_write((3 << 10) | (21 << 5), 32'hB11B_0021, w);
    f0 = fills;
    a = (2 << 10) | (22 << 5);
    cpu_read(a, d, lat);
    chk(fills == f0 + 1 && d == gold[a[11:2]], "R11 fill data", d, gold[a[11:2]]);
    chk(mem_wr_valid == 1'b1, "R11 store still queued", mem_wr_valid, 1);
    chk(lat < 12, "R11 fill not delayed", lat, 11);
    drain();

    // R7 final memory image equals model
    for (int i = 0; i < 1024; i++)
      if (bmem[i] != gold[i]) chk(1'b0, "R7 memory image", bmem[i], gold[i]);
    chk(exp_rd == exp_wr, "R7 all stores written", exp_rd, exp_wr);
    finish_run();
  end
endmodule